// File: doc/BRIEF.md
# Power-over-Ethernet Port Detection Sequencer

This block is the control sequencer for one Power-over-Ethernet sourcing port. When reset is released it keeps a copy of three configuration straps: midspan cadence enable, high-capacitance acceptance and oscillator select. From then on it runs the port by itself. It asks an external measurement engine to probe for a powered device. On a valid signature it asks for classification. When classification passes, it closes the pass switch.

A failed probe is retried with no limit. If the midspan strap was set at reset, every failed probe is followed by a back-off of a bounded number of slow ticks, typically 1 ms each, before the next probe. The very first probe after reset never waits. A failed classification returns the port to probing. So does a power fault while the port is on, and the switch opens in the same cycle. The two strap values that the measurement engine consumes are brought out as frozen copies. The strap pads carry pull-ups, so an undriven strap reads as enabled.

Top module: `poe_port_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the state output becomes IDLE (code 0) and `det_start_o`, `cls_start_o` and `gate_en_o` become 0. The state codes are IDLE=0, DETECT=1, CADENCE_WAIT=2, CLASSIFY=3, POWER_ON=4, and no other code ever appears.
- R2: The straps are copied at every clock edge that sees `rst` high. Afterwards `cfg_highcap_o` and `cfg_osc_o` keep those values, and so does the midspan behaviour, whatever the strap inputs do until the next reset.
- R3: At the first clock edge that sees `rst` low, the state moves from IDLE to DETECT and `det_start_o` is 1 for that one cycle. This holds with midspan on or off. `det_start_o` is a one-cycle pulse in the first cycle of each stay in DETECT, and it is never high in any other state.
- R4: With midspan latched off, `det_done_i`=1 with `det_valid_i`=0 in DETECT re-enters DETECT at the next edge with a fresh `det_start_o` pulse. This repeats for as many failures as occur.
- R5: With midspan latched on, a failed detection moves to CADENCE_WAIT. The state stays there until LOAD ticks have been sampled, counting from the cycle after entry, and moves to DETECT with a `det_start_o` pulse at the edge that samples the last of them. LOAD is WAIT_TICKS clamped to the range MIN_TICKS+1 to MAX_TICKS, which gives 2001 to 2400 ticks by default.
- R6: `det_done_i`=1 with `det_valid_i`=1 in DETECT moves to CLASSIFY. `cls_start_o` is 1 in the first cycle there and only in CLASSIFY.
- R7: `cls_done_i`=1 with `cls_valid_i`=1 in CLASSIFY moves to POWER_ON with `gate_en_o`=1 from that same cycle.
- R8: `cls_done_i`=1 with `cls_valid_i`=0 in CLASSIFY returns to DETECT with a `det_start_o` pulse and `gate_en_o`=0.
- R9: `pwr_fault_i` in POWER_ON returns to DETECT at the next edge, with `gate_en_o` low and a `det_start_o` pulse. In any other state it has no effect.
- R10: `gate_en_o` is 0 in every state except POWER_ON.
- R11: Result strobes and ticks have no effect outside the state that consumes them. `det_done_i` acts only in DETECT, `cls_done_i` only in CLASSIFY, and `tick_i` only in CADENCE_WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are copied while it is high |
| strap_midspan_i | input | 1 | Strap: enable back-off after failed detection |
| strap_highcap_i | input | 1 | Strap: accept high signature capacitance |
| strap_osc_i | input | 1 | Strap: oscillator select |
| tick_i | input | 1 | One-cycle tick enable, nominally every 1 ms |
| det_done_i | input | 1 | Detection result strobe |
| det_valid_i | input | 1 | Detection result, 1 = valid signature |
| cls_done_i | input | 1 | Classification result strobe |
| cls_valid_i | input | 1 | Classification result, 1 = pass |
| pwr_fault_i | input | 1 | Power fault while the port is on |
| det_start_o | output | 1 | One-cycle request to start a detection |
| cls_start_o | output | 1 | One-cycle request to start a classification |
| gate_en_o | output | 1 | Pass switch enable |
| state_o | output | 3 | Current state code |
| cfg_highcap_o | output | 1 | Frozen high-capacitance strap |
| cfg_osc_o | output | 1 | Frozen oscillator-select strap |

## Verification
The bench sweeps the tick spacing from every cycle to every fourth cycle during the back-off. It checks that the exit comes on exactly the LOAD-th tick. An off-by-one counter, or one that counts a tick in its load cycle, shows up as a wait one tick short or long. It flips the straps after reset, and a design that samples them continuously then shows cadence waits or changed configuration outputs. It also drives a midspan reset, to catch a design that waits before the first probe. Stray result strobes, ticks and faults are injected in states that must ignore them. A design that decodes strobes in every state would then jump to the wrong state or open the switch early.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DETECT   = 3'd1,
        ST_CADENCE  = 3'd2,
        ST_CLASSIFY = 3'd3,
        ST_POWER    = 3'd4
    } port_state_e;

    typedef struct packed {
        logic midspan;
        logic highcap;
        logic osc_sel;
    } strap_cfg_t;

    typedef struct packed {
        port_state_e state;
        logic        det_req;
        logic        cls_req;
        logic        gate_on;
    } fsm_regs_t;

endpackage

// File: rtl/poe_strap_capture.sv
module poe_strap_capture
    import poe_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  strap_cfg_t straps_i,
    output strap_cfg_t cfg_o
);

    strap_cfg_t cfg_d, cfg_q;

    // Follow the pads only while reset is held; freeze afterwards.
    always_comb begin
        cfg_d = cfg_q;
        if (rst) begin
            cfg_d = straps_i;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/poe_cadence_timer.sv
module poe_cadence_timer #(
    parameter int MIN_TICKS  = 2000,
    parameter int MAX_TICKS  = 2400,
    parameter int WAIT_TICKS = 2200
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic tick_i,
    output logic done_o
);

    localparam int CW = $clog2(MAX_TICKS + 1);
    // One tick of phase uncertainty is absorbed by keeping the load above MIN.
    localparam int LOAD_TICKS = (WAIT_TICKS <= MIN_TICKS) ? MIN_TICKS + 1 :
                                (WAIT_TICKS >  MAX_TICKS) ? MAX_TICKS : WAIT_TICKS;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (rst) begin
            tmr_d.cnt = '0;
            tmr_d.run = 1'b0;
        end else if (load_i) begin
            tmr_d.cnt = CW'(LOAD_TICKS);
            tmr_d.run = 1'b1;
        end else if (tmr_q.run && tick_i) begin
            tmr_d.cnt = tmr_q.cnt - CW'(1);
            if (tmr_q.cnt == CW'(1)) begin
                tmr_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end

    assign done_o = tmr_q.run && tick_i && (tmr_q.cnt == CW'(1));

endmodule

// File: rtl/poe_port_fsm.sv
module poe_port_fsm
    import poe_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      midspan_i,
    input  logic      det_done_i,
    input  logic      det_valid_i,
    input  logic      cls_done_i,
    input  logic      cls_valid_i,
    input  logic      pwr_fault_i,
    input  logic      wait_done_i,
    output logic      wait_load_o,
    output fsm_regs_t regs_o
);

    fsm_regs_t fsm_d, fsm_q;
    logic      load_d;

    always_comb begin
        fsm_d         = fsm_q;
        fsm_d.det_req = 1'b0;
        fsm_d.cls_req = 1'b0;
        load_d        = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                fsm_d.state   = ST_DETECT;
                fsm_d.det_req = 1'b1;
                fsm_d.gate_on = 1'b0;
            end
            ST_DETECT: begin
                if (det_done_i) begin
                    if (det_valid_i) begin
                        fsm_d.state   = ST_CLASSIFY;
                        fsm_d.cls_req = 1'b1;
                    end else if (midspan_i) begin
                        fsm_d.state = ST_CADENCE;
                        load_d      = 1'b1;
                    end else begin
                        fsm_d.state   = ST_DETECT;
                        fsm_d.det_req = 1'b1;
                    end
                end
            end
            ST_CADENCE: begin
                if (wait_done_i) begin
                    fsm_d.state   = ST_DETECT;
                    fsm_d.det_req = 1'b1;
                end
            end
            ST_CLASSIFY: begin
                if (cls_done_i) begin
                    if (cls_valid_i) begin
                        fsm_d.state   = ST_POWER;
                        fsm_d.gate_on = 1'b1;
                    end else begin
                        fsm_d.state   = ST_DETECT;
                        fsm_d.det_req = 1'b1;
                        fsm_d.gate_on = 1'b0;
                    end
                end
            end
            ST_POWER: begin
                if (pwr_fault_i) begin
                    fsm_d.state   = ST_DETECT;
                    fsm_d.det_req = 1'b1;
                    fsm_d.gate_on = 1'b0;
                end
            end
            default: begin
                fsm_d.state   = ST_IDLE;
                fsm_d.gate_on = 1'b0;
            end
        endcase
        if (rst) begin
            fsm_d.state   = ST_IDLE;
            fsm_d.det_req = 1'b0;
            fsm_d.cls_req = 1'b0;
            fsm_d.gate_on = 1'b0;
            load_d        = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        fsm_q <= fsm_d;
    end

    assign wait_load_o = load_d;
    assign regs_o      = fsm_q;

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int MIN_TICKS  = 2000,
    parameter int MAX_TICKS  = 2400,
    parameter int WAIT_TICKS = 2200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       strap_midspan_i,
    input  logic       strap_highcap_i,
    input  logic       strap_osc_i,
    input  logic       tick_i,
    input  logic       det_done_i,
    input  logic       det_valid_i,
    input  logic       cls_done_i,
    input  logic       cls_valid_i,
    input  logic       pwr_fault_i,
    output logic       det_start_o,
    output logic       cls_start_o,
    output logic       gate_en_o,
    output logic [2:0] state_o,
    output logic       cfg_highcap_o,
    output logic       cfg_osc_o
);

    strap_cfg_t straps_in;
    strap_cfg_t cfg_q;
    fsm_regs_t  regs;
    logic       wait_load;
    logic       wait_done;

    assign straps_in.midspan = strap_midspan_i;
    assign straps_in.highcap = strap_highcap_i;
    assign straps_in.osc_sel = strap_osc_i;

    poe_strap_capture i_straps (
        .clk      (clk),
        .rst      (rst),
        .straps_i (straps_in),
        .cfg_o    (cfg_q)
    );

    poe_cadence_timer #(
        .MIN_TICKS  (MIN_TICKS),
        .MAX_TICKS  (MAX_TICKS),
        .WAIT_TICKS (WAIT_TICKS)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (wait_load),
        .tick_i (tick_i),
        .done_o (wait_done)
    );

    poe_port_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .midspan_i   (cfg_q.midspan),
        .det_done_i  (det_done_i),
        .det_valid_i (det_valid_i),
        .cls_done_i  (cls_done_i),
        .cls_valid_i (cls_valid_i),
        .pwr_fault_i (pwr_fault_i),
        .wait_done_i (wait_done),
        .wait_load_o (wait_load),
        .regs_o      (regs)
    );

    assign det_start_o   = regs.det_req;
    assign cls_start_o   = regs.cls_req;
    assign gate_en_o     = regs.gate_on;
    assign state_o       = regs.state;
    assign cfg_highcap_o = cfg_q.highcap;
    assign cfg_osc_o     = cfg_q.osc_sel;

endmodule

// File: rtl/poe_port_seq_checker.sv
module poe_port_seq_checker
    import poe_seq_pkg::*;
#(
    parameter int MIN_TICKS  = 2000,
    parameter int MAX_TICKS  = 2400,
    parameter int WAIT_TICKS = 2200
) (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       pwr_fault_i,
    input logic       det_start_o,
    input logic       cls_start_o,
    input logic       gate_en_o,
    input logic [2:0] state_o,
    input logic       midspan_q,
    input logic       cfg_highcap_o,
    input logic       cfg_osc_o
);

    localparam int EXP_LOAD = (WAIT_TICKS <= MIN_TICKS) ? MIN_TICKS + 1 :
                              (WAIT_TICKS >  MAX_TICKS) ? MAX_TICKS : WAIT_TICKS;

    int ticks_seen;

    always_ff @(posedge clk) begin
        if (rst || state_o != ST_CADENCE) begin
            ticks_seen <= 0;
        end else if (tick_i) begin
            ticks_seen <= ticks_seen + 1;
        end
    end

    assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
        state_o <= 3'd4);

    assert_straps_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst)) |-> ($stable(cfg_highcap_o) && $stable(cfg_osc_o) && $stable(midspan_q)));

    assert_first_probe_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> (state_o == ST_DETECT && det_start_o));

    assert_det_req_state_R3: assert property (@(posedge clk) disable iff (rst)
        det_start_o |-> state_o == ST_DETECT);

    assert_no_wait_plain_R4: assert property (@(posedge clk) disable iff (rst)
        !midspan_q |-> state_o != ST_CADENCE);

    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_CADENCE && !(tick_i && ticks_seen == EXP_LOAD - 1))
        |=> state_o == ST_CADENCE);

    assert_wait_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_CADENCE && tick_i && ticks_seen == EXP_LOAD - 1)
        |=> (state_o == ST_DETECT && det_start_o));

    assert_cls_req_state_R6: assert property (@(posedge clk) disable iff (rst)
        cls_start_o |-> state_o == ST_CLASSIFY);

    assert_fault_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_POWER && pwr_fault_i) |=> (state_o == ST_DETECT && !gate_en_o));

    assert_gate_only_on_R10: assert property (@(posedge clk) disable iff (rst)
        gate_en_o |-> state_o == ST_POWER);

endmodule

bind poe_port_seq poe_port_seq_checker #(
    .MIN_TICKS  (MIN_TICKS),
    .MAX_TICKS  (MAX_TICKS),
    .WAIT_TICKS (WAIT_TICKS)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .pwr_fault_i   (pwr_fault_i),
    .det_start_o   (det_start_o),
    .cls_start_o   (cls_start_o),
    .gate_en_o     (gate_en_o),
    .state_o       (state_o),
    .midspan_q     (cfg_q.midspan),
    .cfg_highcap_o (cfg_highcap_o),
    .cfg_osc_o     (cfg_osc_o)
);

// File: tb/test_poe_port_seq.sv
module test_poe_port_seq;

    localparam int CLK_PERIOD = 10;
    localparam int T_MIN      = 4;
    localparam int T_MAX      = 8;
    localparam int T_WAIT     = 6;
    localparam int EXP_LOAD   = 6;   // T_WAIT lies inside (T_MIN, T_MAX]

    localparam int S_IDLE = 0, S_DET = 1, S_WAIT = 2, S_CLS = 3, S_PWR = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_midspan = 1'b0, strap_highcap = 1'b0, strap_osc = 1'b0;
    logic       tick = 1'b0;
    logic       det_done = 1'b0, det_valid = 1'b0;
    logic       cls_done = 1'b0, cls_valid = 1'b0;
    logic       pwr_fault = 1'b0;
    logic       det_start, cls_start, gate_en, cfg_highcap, cfg_osc;
    logic [2:0] state;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    poe_port_seq #(
        .MIN_TICKS  (T_MIN),
        .MAX_TICKS  (T_MAX),
        .WAIT_TICKS (T_WAIT)
    ) i_poe_port_seq (
        .clk             (clk),
        .rst             (rst),
        .strap_midspan_i (strap_midspan),
        .strap_highcap_i (strap_highcap),
        .strap_osc_i     (strap_osc),
        .tick_i          (tick),
        .det_done_i      (det_done),
        .det_valid_i     (det_valid),
        .cls_done_i      (cls_done),
        .cls_valid_i     (cls_valid),
        .pwr_fault_i     (pwr_fault),
        .det_start_o     (det_start),
        .cls_start_o     (cls_start),
        .gate_en_o       (gate_en),
        .state_o         (state),
        .cfg_highcap_o   (cfg_highcap),
        .cfg_osc_o       (cfg_osc)
    );

    task automatic check(input string req, input int actual, input int expected);
        vectors++;
        if (actual != expected) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_outs(input string req, input int st, input int ds,
                               input int cs, input int ge);
        check({req, " state"}, int'(state), st);
        check({req, " det_start"}, int'(det_start), ds);
        check({req, " cls_start"}, int'(cls_start), cs);
        check({req, " gate"}, int'(gate_en), ge);
    endtask

    task automatic do_reset(input logic mid, input logic hc, input logic osc);
        rst = 1'b1;
        strap_midspan = mid; strap_highcap = hc; strap_osc = osc;
        repeat (3) step();
        expect_outs("R1 reset", S_IDLE, 0, 0, 0);
        rst = 1'b0;
        step();
        expect_outs("R3 first probe", S_DET, 1, 0, 0);
        check("R2 highcap", int'(cfg_highcap), int'(hc));
        check("R2 osc", int'(cfg_osc), int'(osc));
        step();
        expect_outs("R3 pulse ends", S_DET, 0, 0, 0);
    endtask

    task automatic strobe_det(input logic valid);
        det_done = 1'b1; det_valid = valid;
        step();
        det_done = 1'b0; det_valid = 1'b0;
    endtask

    task automatic strobe_cls(input logic valid);
        cls_done = 1'b1; cls_valid = valid;
        step();
        cls_done = 1'b0; cls_valid = 1'b0;
    endtask

    task automatic sweep_wait(input int gap);
        int  n    = 0;
        bit  left = 1'b0;
        strobe_det(1'b0);
        expect_outs("R5 enter wait", S_WAIT, 0, 0, 0);
        // stray detection result during the wait (R11)
        det_done = 1'b1; det_valid = 1'b1;
        step();
        det_done = 1'b0; det_valid = 1'b0;
        check("R11 det_done in wait", int'(state), S_WAIT);
        for (int k = 0; k < 200 && !left; k++) begin
            tick = ((k % (gap + 1)) == gap);
            step();
            if (tick) n++;
            if (state == 3'(S_DET)) begin
                left = 1'b1;
                check("R5 ticks at exit", n, EXP_LOAD);
                check("R5 exit pulse", int'(det_start), 1);
            end else begin
                check("R5 still waiting", int'(state), S_WAIT);
                if (n >= EXP_LOAD) check("R5 overdue", n, EXP_LOAD - 1);
            end
        end
        tick = 1'b0;
        check("R5 wait ended", int'(left), 1);
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // --- plain mode -------------------------------------------------
        do_reset(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            strobe_det(1'b0);
            expect_outs("R4 retry", S_DET, 1, 0, 0);
            step();
        end

        // straps change after reset: no effect (R2)
        strap_midspan = 1'b1; strap_highcap = 1'b0; strap_osc = 1'b1;
        step();
        check("R2 highcap frozen", int'(cfg_highcap), 1);
        check("R2 osc frozen", int'(cfg_osc), 0);
        strobe_det(1'b0);
        expect_outs("R2 midspan frozen", S_DET, 1, 0, 0);
        step();

        // detect ok -> classify
        strobe_det(1'b1);
        expect_outs("R6 classify", S_CLS, 0, 1, 0);
        tick = 1'b1; pwr_fault = 1'b1; det_done = 1'b1; det_valid = 1'b0;
        step();
        tick = 1'b0; pwr_fault = 1'b0; det_done = 1'b0;
        expect_outs("R11 strays in classify", S_CLS, 0, 0, 0);

        strobe_cls(1'b0);
        expect_outs("R8 class fail", S_DET, 1, 0, 0);
        step();

        strobe_det(1'b1);
        strobe_cls(1'b1);
        expect_outs("R7 power on", S_PWR, 0, 0, 1);
        det_done = 1'b1; det_valid = 1'b0; cls_done = 1'b1; tick = 1'b1;
        step();
        det_done = 1'b0; cls_done = 1'b0; tick = 1'b0;
        expect_outs("R11 strays in power", S_PWR, 0, 0, 1);

        pwr_fault = 1'b1;
        step();
        pwr_fault = 1'b0;
        expect_outs("R9 fault drop", S_DET, 1, 0, 0);
        pwr_fault = 1'b1; cls_done = 1'b1; cls_valid = 1'b1;
        step();
        pwr_fault = 1'b0; cls_done = 1'b0; cls_valid = 1'b0;
        expect_outs("R9 fault ignored in detect", S_DET, 0, 0, 0);

        // --- midspan mode -----------------------------------------------
        do_reset(1'b1, 1'b0, 1'b1);
        for (int g = 0; g < 4; g++) begin
            sweep_wait(g);
        end
        strap_midspan = 1'b0;
        step();
        strobe_det(1'b0);
        expect_outs("R2 midspan kept", S_WAIT, 0, 0, 0);
        tick = 1'b1;
        repeat (EXP_LOAD) step();
        tick = 1'b0;
        expect_outs("R5 back to detect", S_DET, 1, 0, 0);
        step();
        strobe_det(1'b1);
        strobe_cls(1'b1);
        expect_outs("R7 midspan power on", S_PWR, 0, 0, 1);
        check("R10 gate in power", int'(gate_en), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule